// File: doc/BRIEF.md
# Read Burst Buffer with Reserved Vacancy

This block sits on the read side of an AXI4 link, between an upstream master and a downstream slave. Read commands from the master go into a short command queue. Read data from the slave goes into a deep beat store and comes back to the master in order. The store holds 512 beats and the command queue holds 32 commands by default.

A command leaves the queue toward the slave only when the beat store can take its whole burst, which is its length field plus one beats. Free space counts only the entries that no earlier issued command has already claimed. The block tracks this with a vacancy counter. The counter starts at the store depth. It drops by the burst size on each command handshake on the slave side, and rises by one for each beat handed to the master. Because the space for every burst is claimed up front, the slave can always stream a whole burst into the store, even when the master drains it slowly. AXI4-Lite traffic is not handled.

Top module: `axi_rd_vacancy_buf`

## Requirements
- R1: While the synchronous active-low reset is held, both queues empty and the vacancy returns to DATA_DEPTH (512). After reset, s_arready=1, m_arvalid=0, s_rvalid=0 and m_rready=1, and two 256-beat bursts can both be issued.
- R2: The command queue holds CMD_DEPTH (32) commands. While m_arready stays low, the first 32 commands are accepted and the 33rd is refused with s_arready low.
- R3: Commands reach the slave side in arrival order with id, addr, len, size and burst unchanged. They stay stable while m_arready is low.
- R4: m_arvalid is high exactly when the queue holds a command and the vacancy is at least that head command's len+1.
- R5: The vacancy starts at 512. It drops by len+1 on each m_ar handshake and rises by one for each s_r handshake. When both happen in the same cycle, the two changes are summed.
- R6: Read beats reach the master in the order the slave sent them, with data, resp, last and id unchanged, and they stay stable while s_rready is low.
- R7: m_rready is low only when 512 beats are stored. s_rvalid is high whenever at least one beat is stored.
- R8: A command accepted at a clock edge is presented on m_ar from the next cycle on, if it fits the vacancy.
- R9: A head command that does not fit blocks every later command, even a later command that would fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_arvalid | input | 1 | Command valid from the master |
| s_arready | output | 1 | Command queue has room |
| s_arid | input | ID_W | Command id |
| s_araddr | input | ADDR_W | Command address |
| s_arlen | input | 8 | Burst length minus one |
| s_arsize | input | 3 | Beat size code |
| s_arburst | input | 2 | Burst type code |
| s_rvalid | output | 1 | Beat available for the master |
| s_rready | input | 1 | Master accepts a beat |
| s_rid | output | ID_W | Beat id |
| s_rdata | output | DATA_W | Beat data |
| s_rresp | output | 2 | Beat response |
| s_rlast | output | 1 | Last beat of burst |
| m_arvalid | output | 1 | Command offered to the slave |
| m_arready | input | 1 | Slave accepts the command |
| m_arid | output | ID_W | Forwarded id |
| m_araddr | output | ADDR_W | Forwarded address |
| m_arlen | output | 8 | Forwarded length |
| m_arsize | output | 3 | Forwarded size |
| m_arburst | output | 2 | Forwarded burst type |
| m_rvalid | input | 1 | Beat from the slave |
| m_rready | output | 1 | Beat store has room |
| m_rid | input | ID_W | Slave beat id |
| m_rdata | input | DATA_W | Slave beat data |
| m_rresp | input | 2 | Slave beat response |
| m_rlast | input | 1 | Slave last beat |

## Verification
If the vacancy count is too high, a command is issued that the store cannot hold. This shows up one cycle later as m_arvalid asserted where the bench's own vacancy model forbids it, and later as m_rready falling before 512 beats are stored. If the vacancy count leaks low, a command that fits stays blocked. The bench sees this at the first cycle where its model expects m_arvalid and the port stays low, and the fill tests catch a missing issue after a few hundred cycles. A broken pointer or stored field shows up on the next beat or command the scoreboard compares.

// File: rtl/rvb_pkg.sv
`timescale 1ns/1ps
package rvb_pkg;
  localparam int LEN_W  = 8;
  localparam int BEAT_W = LEN_W + 1;

  // number of beats a command claims
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [LEN_W-1:0] len);
    return BEAT_W'(len) + BEAT_W'(1);
  endfunction

  // vacancy after one cycle of claims and releases
  function automatic logic [31:0] credit_after(input logic [31:0] cur,
                                               input logic [31:0] taken,
                                               input logic give);
    return cur - taken + (give ? 32'd1 : 32'd0);
  endfunction

  // does the vacancy cover the burst
  function automatic logic covers(input logic [31:0] cred, input logic [LEN_W-1:0] len);
    return cred >= 32'(burst_beats(len));
  endfunction
endpackage

// File: rtl/rvb_sync_fifo.sv
`timescale 1ns/1ps
module rvb_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic [LW-1:0]    level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [LW-1:0]    count;
  logic             push, pop;

  assign wr_ready = (count != LW'(DEPTH));
  assign rd_valid = (count != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr];
  assign level    = count;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R2
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level == $past(level) + LW'(1))); // R6
endmodule

// File: rtl/rvb_credit.sv
`timescale 1ns/1ps
module rvb_credit #(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [rvb_pkg::LEN_W-1:0] head_len,
  output logic                    head_fits,
  input  logic                    take,
  input  logic                    give,
  output logic [CW-1:0]           credit
);
  logic [CW-1:0] credit_q;
  logic [31:0]   take_amt;

  assign credit    = credit_q;
  assign head_fits = rvb_pkg::covers(32'(credit_q), head_len);
  assign take_amt  = take ? 32'(rvb_pkg::burst_beats(head_len)) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= CW'(DEPTH);
    end else if (take || give) begin
      credit_q <= CW'(rvb_pkg::credit_after(32'(credit_q), take_amt, give));
    end
  end

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CW'(DEPTH)); // R5
  AST_GIVE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |=> (credit_q == $past(credit_q) + CW'(1))); // R5
endmodule

// File: rtl/axi_rd_vacancy_buf.sv
`timescale 1ns/1ps
module axi_rd_vacancy_buf #(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CMD_DEPTH  = 32,
  parameter int DATA_DEPTH = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  input  logic [ID_W-1:0]           s_arid,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic [rvb_pkg::LEN_W-1:0] s_arlen,
  input  logic [2:0]                s_arsize,
  input  logic [1:0]                s_arburst,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  output logic [ID_W-1:0]           s_rid,
  output logic [DATA_W-1:0]         s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rlast,
  output logic                      m_arvalid,
  input  logic                      m_arready,
  output logic [ID_W-1:0]           m_arid,
  output logic [ADDR_W-1:0]         m_araddr,
  output logic [rvb_pkg::LEN_W-1:0] m_arlen,
  output logic [2:0]                m_arsize,
  output logic [1:0]                m_arburst,
  input  logic                      m_rvalid,
  output logic                      m_rready,
  input  logic [ID_W-1:0]           m_rid,
  input  logic [DATA_W-1:0]         m_rdata,
  input  logic [1:0]                m_rresp,
  input  logic                      m_rlast
);
  localparam int CMD_W  = ID_W + ADDR_W + rvb_pkg::LEN_W + 3 + 2;
  localparam int BEAT_W = ID_W + 2 + 1 + DATA_W;
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1);
  localparam int DAT_LW = $clog2(DATA_DEPTH + 1);

  logic [CMD_W-1:0]  cmd_in, cmd_out;
  logic [BEAT_W-1:0] beat_in, beat_out;
  logic [CMD_LW-1:0] cmd_level;
  logic [DAT_LW-1:0] data_level;
  logic [DAT_LW-1:0] credit;
  logic              cmd_avail, head_fits;
  // named events for the checks
  logic              ar_out_fire, r_out_fire;

  assign cmd_in = {s_arid, s_araddr, s_arlen, s_arsize, s_arburst};
  assign {m_arid, m_araddr, m_arlen, m_arsize, m_arburst} = cmd_out;
  assign m_arvalid   = cmd_avail && head_fits;
  assign ar_out_fire = m_arvalid && m_arready;

  rvb_sync_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(s_arvalid), .wr_ready(s_arready), .wr_data(cmd_in),
    .rd_valid(cmd_avail), .rd_ready(m_arready && head_fits), .rd_data(cmd_out),
    .level(cmd_level)
  );

  rvb_credit #(.DEPTH(DATA_DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .head_len(m_arlen), .head_fits(head_fits),
    .take(ar_out_fire), .give(r_out_fire), .credit(credit)
  );

  assign beat_in = {m_rid, m_rresp, m_rlast, m_rdata};
  assign {s_rid, s_rresp, s_rlast, s_rdata} = beat_out;
  assign r_out_fire = s_rvalid && s_rready;

  rvb_sync_fifo #(.WIDTH(BEAT_W), .DEPTH(DATA_DEPTH)) u_beatq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(m_rvalid), .wr_ready(m_rready), .wr_data(beat_in),
    .rd_valid(s_rvalid), .rd_ready(s_rready), .rd_data(beat_out),
    .level(data_level)
  );

  AST_RESERVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(credit) + 32'(data_level)) <= 32'(DATA_DEPTH)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rready |-> (credit == '0)); // R7
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen))); // R3
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rlast))); // R6
  AST_CMD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !s_arready |-> (cmd_level == CMD_LW'(CMD_DEPTH))); // R2
endmodule

// File: tb/axi_rd_vacancy_buf_test.sv
`timescale 1ns/1ps
module axi_rd_vacancy_buf_test;
  typedef struct packed { logic [3:0] id; logic [31:0] addr; logic [7:0] len; } ar_t;
  typedef struct packed { logic [3:0] id; logic [1:0] resp; logic last; logic [31:0] data; } beat_t;

  logic clk = 0, rst_n = 0;
  logic s_arvalid = 0, s_rready = 0, m_arready = 0, m_rvalid = 0;
  logic [3:0] s_arid = 0, m_rid = 0, s_rid, m_arid;
  logic [31:0] s_araddr = 0, m_rdata = 0, s_rdata, m_araddr;
  logic [7:0] s_arlen = 0, m_arlen;
  logic [2:0] s_arsize = 3'd2, m_arsize;
  logic [1:0] s_arburst = 2'b01, m_arburst, s_rresp, m_rresp = 0;
  logic s_arready, s_rvalid, s_rlast, m_arvalid, m_rready, m_rlast = 0;

  ar_t   exp_ar[$];
  beat_t exp_r[$];
  beat_t slv_q[$];
  int n_chk = 0, n_bad = 0, cred_m = 512, in_fifo = 0, stored = 0, fwd_cnt = 0, cyc = 0;
  bit slv_en = 0, slv_gap = 0;

  axi_rd_vacancy_buf uut (
    .clk(clk), .rst_n(rst_n),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid), .s_araddr(s_araddr),
    .s_arlen(s_arlen), .s_arsize(s_arsize), .s_arburst(s_arburst),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rlast(s_rlast),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_araddr(m_araddr),
    .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid), .m_rdata(m_rdata),
    .m_rresp(m_rresp), .m_rlast(m_rlast)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic beat_t mk_beat(input ar_t a, input int i);
    beat_t b;
    b.id = a.id;
    b.resp = a.id[1:0];
    b.last = (i == int'(a.len));
    b.data = (a.addr + 32'(i * 16)) ^ 32'h5A00_0000;
    return b;
  endfunction

  // driver: offers one command, records what must come out
  task automatic try_ar(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                        input int limit, output bit ok);
    ar_t a;
    int waited;
    a = '{id, addr, len};
    waited = 0;
    @(negedge clk);
    s_arvalid = 1; s_arid = id; s_araddr = addr; s_arlen = len;
    #1;
    while (!s_arready && waited < limit) begin
      @(negedge clk); #1; waited++;
    end
    ok = s_arready;
    if (ok) begin
      exp_ar.push_back(a);
      for (int i = 0; i <= int'(len); i++) exp_r.push_back(mk_beat(a, i));
    end
    @(negedge clk);
    s_arvalid = 0;
  endtask

  task automatic send_ar(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len);
    bit ok;
    try_ar(id, addr, len, 100000, ok);
  endtask

  task automatic wait_drain();
    while (exp_r.size() != 0 || exp_ar.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // slave model and monitor
  initial begin
    forever begin
      bit want;
      ar_t got_a;
      beat_t got_b;
      @(negedge clk);
      if (rst_n && slv_en && slv_q.size() > 0 && !(slv_gap && cyc[0])) begin
        m_rvalid = 1;
        {m_rid, m_rresp, m_rlast, m_rdata} = slv_q[0];
      end else begin
        m_rvalid = 0;
      end
      #1;
      if (rst_n) begin
        want = (in_fifo > 0) ? (cred_m >= int'(exp_ar[0].len) + 1) : 1'b0;
        chk(m_arvalid == want, "R4 m_arvalid vs vacancy", 64'(m_arvalid), 64'(want));
        chk(m_rready == (stored != 512), "R7 m_rready vs stored", 64'(m_rready), 64'(stored != 512));
        chk(s_rvalid == (stored != 0), "R7 s_rvalid vs stored", 64'(s_rvalid), 64'(stored != 0));
        if (m_arvalid && m_arready && in_fifo > 0) begin
          got_a = '{m_arid, m_araddr, m_arlen};
          chk(got_a == exp_ar[0] && m_arsize == 3'd2 && m_arburst == 2'b01,
              "R3 forwarded command", 64'(got_a), 64'(exp_ar[0]));
          for (int i = 0; i <= int'(exp_ar[0].len); i++) slv_q.push_back(mk_beat(exp_ar[0], i));
          cred_m -= int'(exp_ar[0].len) + 1;
          void'(exp_ar.pop_front());
          in_fifo--;
          fwd_cnt++;
        end
        if (m_rvalid && m_rready) begin
          void'(slv_q.pop_front());
          stored++;
        end
        if (s_rvalid && s_rready) begin
          got_b = {s_rid, s_rresp, s_rlast, s_rdata};
          if (exp_r.size() > 0) begin
            chk(got_b == exp_r[0], "R6 returned beat", 64'(got_b), 64'(exp_r[0]));
            void'(exp_r.pop_front());
          end else chk(0, "R6 unexpected beat", 64'(got_b), 64'(0));
          stored--;
          cred_m++;  // R5 release by one
        end
        if (s_arvalid && s_arready) in_fifo++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(s_arready == 1, "R1 s_arready after reset", 64'(s_arready), 1);
    chk(m_arvalid == 0, "R1 m_arvalid after reset", 64'(m_arvalid), 0);
    chk(s_rvalid == 0, "R1 s_rvalid after reset", 64'(s_rvalid), 0);
    chk(m_rready == 1, "R1 m_rready after reset", 64'(m_rready), 1);

    // basic flow and one-cycle issue latency
    s_rready = 1; m_arready = 1; slv_en = 1;
    send_ar(4'd1, 32'h1000, 8'd0);
    #1;
    chk(m_arvalid == 1, "R8 issue one cycle after accept", 64'(m_arvalid), 1);
    send_ar(4'd2, 32'h1100, 8'd3);
    slv_gap = 1;
    send_ar(4'd3, 32'h1200, 8'd7);
    send_ar(4'd6, 32'h1300, 8'd15);
    wait_drain();
    slv_gap = 0;

    // vacancy gating, head-of-line blocking, full store
    s_rready = 0;
    base = fwd_cnt;
    send_ar(4'd2, 32'h2000, 8'd255);
    send_ar(4'd3, 32'h3000, 8'd254);
    send_ar(4'd4, 32'h4000, 8'd1);
    send_ar(4'd5, 32'h5000, 8'd0);
    repeat (600) @(negedge clk);
    #1;
    chk(fwd_cnt == base + 2, "R9 two-beat head blocks one-beat follower", 64'(fwd_cnt - base), 2);
    chk(m_arvalid == 0, "R4 vacancy 1 below need 2", 64'(m_arvalid), 0);
    chk(m_rready == 1, "R7 room with 511 stored", 64'(m_rready), 1);
    @(negedge clk); s_rready = 1;
    @(negedge clk); s_rready = 0;
    repeat (20) @(negedge clk);
    #1;
    chk(fwd_cnt == base + 3, "R5 one released beat lets two-beat burst go", 64'(fwd_cnt - base), 3);
    chk(m_arvalid == 0, "R4 zero vacancy holds one-beat burst", 64'(m_arvalid), 0);
    chk(m_rready == 0, "R7 store full at 512", 64'(m_rready), 0);
    s_rready = 1;
    wait_drain();
    chk(fwd_cnt == base + 4, "R9 follower issued after drain", 64'(fwd_cnt - base), 4);

    // command queue depth
    m_arready = 0;
    for (int i = 0; i < 32; i++) send_ar(4'd6, 32'h6000 + 32'(i * 4), 8'd0);
    try_ar(4'd7, 32'h7000, 8'd0, 20, ok);
    #1;
    chk(!ok, "R2 33rd command refused", 64'(ok), 0);
    chk(s_arready == 0, "R2 s_arready low when 32 held", 64'(s_arready), 0);
    m_arready = 1;
    wait_drain();

    // reset in the middle of traffic
    s_rready = 0;
    send_ar(4'd8, 32'h8000, 8'd3);
    repeat (10) @(negedge clk);
    rst_n = 0;
    exp_ar.delete(); exp_r.delete(); slv_q.delete();
    cred_m = 512; in_fifo = 0; stored = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk(s_rvalid == 0, "R1 store emptied by reset", 64'(s_rvalid), 0);
    chk(m_rready == 1, "R1 room after reset", 64'(m_rready), 1);
    base = fwd_cnt;
    send_ar(4'd9, 32'h9000, 8'd255);
    send_ar(4'd10, 32'hA000, 8'd255);
    repeat (600) @(negedge clk);
    #1;
    chk(fwd_cnt == base + 2, "R1 full vacancy restored", 64'(fwd_cnt - base), 2);
    chk(m_rready == 0, "R7 full after two 256-beat bursts", 64'(m_rready), 0);
    s_rready = 1;
    wait_drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule